// File: doc/BRIEF.md
# Macro-Instruction Cracker

This block sits between instruction decode and the micro-op back end. It takes one decoded register/memory macro-instruction per valid/ready handshake and turns it into simple load/store-style micro-ops. The micro-ops leave one per cycle on a valid/ready output, in program order. The final micro-op of each macro-instruction carries a last flag.

The number of micro-ops depends on the operand form:

- A register-register ALU operation becomes a single micro-op.
- A memory-source ALU operation becomes a load into a hidden temporary register, followed by the ALU operation that reads it.
- A memory-destination ALU operation becomes load, operate, store.
- One block-copy step expands to a fixed six-micro-op loop body.

The temporary register uses the one register index above the visible register range, so it can never collide with a programmer-visible register.

Top module: `mc_cracker`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: in_ready is 1 exactly when no macro-instruction is in progress. A macro-instruction is accepted on an edge where in_valid and in_ready are both 1. While one is in progress, in_valid and the input fields are ignored. In the cycle after its last micro-op is taken, out_valid is 0 and in_ready is 1.
- R3: Form 0 (register-register) produces one micro-op: kind ALU (code 0), alu = op, rd = rd, rs1 = rd, rs2 = rs, imm = 0, last = 1.
- R4: Form 1 (memory source) produces two micro-ops. The first is LOAD (code 1) with rd = T, rs1 = rb, rs2 = 0, imm = off, alu = 0. The second is ALU with rd = rd, rs1 = rd, rs2 = T, imm = 0, last = 1.
- R5: Form 2 (memory destination) produces three micro-ops. The first is LOAD as in R4. The second is ALU with rd = T, rs1 = T, rs2 = rs, imm = 0. The third is STORE (code 2) with rd = 0, rs1 = rb, rs2 = T, imm = off, alu = 0, last = 1.
- R6: Form 3 (copy step) produces six micro-ops, in this order:
  - LOAD rd = T, rs1 = rs, imm = 0;
  - STORE rs1 = rd, rs2 = T, imm = 0;
  - ADDI (code 3) rd = rs1 = rs, imm = COPY_STEP;
  - ADDI rd = rs1 = rd, imm = COPY_STEP;
  - ADDI rd = rs1 = rb, imm = all ones (minus one);
  - BNZ (code 4) rd = 0, rs1 = rb, imm = off, last = 1.

  In all of these, fields not listed are 0.
- R7: Micro-op register fields are REG_W+1 bits wide. Visible registers are zero-extended. The temporary T is index 2**REG_W.
- R8: While out_valid is 1 and out_ready is 0, every output field holds its value on the next cycle.
- R9: Only the final micro-op of a macro-instruction has last = 1. Micro-ops leave in the order listed, with none skipped or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Macro-instruction offered |
| in_ready | output | 1 | Cracker idle, can accept |
| in_form | input | 2 | Operand form code (0..3) |
| in_op | input | ALU_W | ALU operation code |
| in_rd | input | REG_W | Destination register (destination pointer for copy) |
| in_rs | input | REG_W | Source register (source pointer for copy) |
| in_rb | input | REG_W | Memory base register (count register for copy) |
| in_off | input | OFF_W | Memory offset / branch displacement |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Consumer takes micro-op |
| out_kind | output | 3 | Micro-op kind code |
| out_alu | output | ALU_W | ALU operation (ALU kind only) |
| out_rd | output | REG_W+1 | Destination register index |
| out_rs1 | output | REG_W+1 | First source / address base |
| out_rs2 | output | REG_W+1 | Second source / store data |
| out_imm | output | OFF_W | Immediate / offset |
| out_last | output | 1 | Final micro-op of this macro-instruction |

## Verification
The bench builds the block with its defaults: REG_W = 4, ALU_W = 4, OFF_W = 8 and COPY_STEP = 4. This gives sixteen visible registers and puts the temporary at index 16. Random register choices therefore regularly hit index 15 next to the hidden one, and offsets reach both 0 and all-ones, so sign and width slips in the minus-one immediate become visible. The random stall pattern on out_ready, together with junk offered on the input while busy, covers the hold and ignore rules in every position of every sequence.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic [1:0] {
        FORM_RR   = 2'd0,
        FORM_RM   = 2'd1,
        FORM_MR   = 2'd2,
        FORM_COPY = 2'd3
    } form_e;

    typedef enum logic [2:0] {
        K_ALU   = 3'd0,
        K_LOAD  = 3'd1,
        K_STORE = 3'd2,
        K_ADDI  = 3'd3,
        K_BNZ   = 3'd4
    } kind_e;

    localparam int MAX_UOPS = 6;
    localparam int IDX_W    = $clog2(MAX_UOPS);
endpackage

// File: rtl/mc_len.sv
module mc_len
    import mc_pkg::*;
(
    input  form_e              form,
    output logic [IDX_W-1:0]   last_idx
);
    always_comb begin
        case (form)
            FORM_RR:   last_idx = IDX_W'(0);
            FORM_RM:   last_idx = IDX_W'(1);
            FORM_MR:   last_idx = IDX_W'(2);
            default:   last_idx = IDX_W'(MAX_UOPS - 1);
        endcase
    end
endmodule

// File: rtl/mc_uop_gen.sv
module mc_uop_gen
    import mc_pkg::*;
#(
    parameter int REG_W     = 4,
    parameter int ALU_W     = 4,
    parameter int OFF_W     = 8,
    parameter int COPY_STEP = 4
) (
    input  form_e               form,
    input  logic [ALU_W-1:0]    op,
    input  logic [REG_W-1:0]    rd,
    input  logic [REG_W-1:0]    rs,
    input  logic [REG_W-1:0]    rb,
    input  logic [OFF_W-1:0]    off,
    input  logic [IDX_W-1:0]    idx,
    output kind_e               kind,
    output logic [ALU_W-1:0]    alu,
    output logic [REG_W:0]      urd,
    output logic [REG_W:0]      urs1,
    output logic [REG_W:0]      urs2,
    output logic [OFF_W-1:0]    imm
);
    localparam int RW = REG_W + 1;
    localparam logic [RW-1:0]    TEMP  = RW'(1) << REG_W;
    localparam logic [OFF_W-1:0] STEP  = OFF_W'(COPY_STEP);
    localparam logic [OFF_W-1:0] MINUS = '1;

    logic [RW-1:0] xrd, xrs, xrb;
    assign xrd = {1'b0, rd};
    assign xrs = {1'b0, rs};
    assign xrb = {1'b0, rb};

    always_comb begin
        kind = K_ALU;
        alu  = '0;
        urd  = '0;
        urs1 = '0;
        urs2 = '0;
        imm  = '0;
        case (form)
            FORM_RR: begin
                alu = op; urd = xrd; urs1 = xrd; urs2 = xrs;
            end
            FORM_RM: begin
                if (idx == IDX_W'(0)) begin
                    kind = K_LOAD; urd = TEMP; urs1 = xrb; imm = off;
                end else begin
                    alu = op; urd = xrd; urs1 = xrd; urs2 = TEMP;
                end
            end
            FORM_MR: begin
                if (idx == IDX_W'(0)) begin
                    kind = K_LOAD; urd = TEMP; urs1 = xrb; imm = off;
                end else if (idx == IDX_W'(1)) begin
                    alu = op; urd = TEMP; urs1 = TEMP; urs2 = xrs;
                end else begin
                    kind = K_STORE; urs1 = xrb; urs2 = TEMP; imm = off;
                end
            end
            default: begin
                case (idx)
                    IDX_W'(0): begin kind = K_LOAD;  urd = TEMP; urs1 = xrs; end
                    IDX_W'(1): begin kind = K_STORE; urs1 = xrd; urs2 = TEMP; end
                    IDX_W'(2): begin kind = K_ADDI;  urd = xrs; urs1 = xrs; imm = STEP; end
                    IDX_W'(3): begin kind = K_ADDI;  urd = xrd; urs1 = xrd; imm = STEP; end
                    IDX_W'(4): begin kind = K_ADDI;  urd = xrb; urs1 = xrb; imm = MINUS; end
                    default:   begin kind = K_BNZ;   urs1 = xrb; imm = off; end
                endcase
            end
        endcase
    end
endmodule

// File: rtl/mc_cracker.sv
module mc_cracker
    import mc_pkg::*;
#(
    parameter int REG_W     = 4,
    parameter int ALU_W     = 4,
    parameter int OFF_W     = 8,
    parameter int COPY_STEP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [1:0]         in_form,
    input  logic [ALU_W-1:0]   in_op,
    input  logic [REG_W-1:0]   in_rd,
    input  logic [REG_W-1:0]   in_rs,
    input  logic [REG_W-1:0]   in_rb,
    input  logic [OFF_W-1:0]   in_off,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [2:0]         out_kind,
    output logic [ALU_W-1:0]   out_alu,
    output logic [REG_W:0]     out_rd,
    output logic [REG_W:0]     out_rs1,
    output logic [REG_W:0]     out_rs2,
    output logic [OFF_W-1:0]   out_imm,
    output logic               out_last
);
    localparam int RW = REG_W + 1;
    localparam logic [RW-1:0] TEMP = RW'(1) << REG_W;

    typedef struct packed {
        logic               busy;
        form_e              form;
        logic [ALU_W-1:0]   op;
        logic [REG_W-1:0]   rd;
        logic [REG_W-1:0]   rs;
        logic [REG_W-1:0]   rb;
        logic [OFF_W-1:0]   off;
        logic [IDX_W-1:0]   idx;
    } state_t;

    state_t st_d, st_q;
    logic [IDX_W-1:0] last_idx;
    logic             is_last;
    kind_e            kind;

    mc_len u_len (
        .form     (st_q.form),
        .last_idx (last_idx)
    );

    mc_uop_gen #(
        .REG_W     (REG_W),
        .ALU_W     (ALU_W),
        .OFF_W     (OFF_W),
        .COPY_STEP (COPY_STEP)
    ) u_gen (
        .form (st_q.form),
        .op   (st_q.op),
        .rd   (st_q.rd),
        .rs   (st_q.rs),
        .rb   (st_q.rb),
        .off  (st_q.off),
        .idx  (st_q.idx),
        .kind (kind),
        .alu  (out_alu),
        .urd  (out_rd),
        .urs1 (out_rs1),
        .urs2 (out_rs2),
        .imm  (out_imm)
    );

    assign is_last   = (st_q.idx == last_idx);
    assign in_ready  = !st_q.busy;
    assign out_valid = st_q.busy;
    assign out_kind  = kind;
    assign out_last  = is_last;

    always_comb begin
        st_d = st_q;
        if (in_valid && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.form = form_e'(in_form);
            st_d.op   = in_op;
            st_d.rd   = in_rd;
            st_d.rs   = in_rs;
            st_d.rb   = in_rb;
            st_d.off  = in_off;
            st_d.idx  = '0;
        end else if (st_q.busy && out_ready) begin
            if (is_last) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_alu)
            && $stable(out_rd) && $stable(out_rs1) && $stable(out_rs2)
            && $stable(out_imm) && $stable(out_last)));

    p_one_inflight_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_free_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

    p_seq_continues_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> out_valid);

    p_load_to_temp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == K_LOAD) |-> (out_rd == TEMP));

    p_branch_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == K_BNZ) |-> out_last);
endmodule

// File: tb/sim_mc_cracker.sv
module sim_mc_cracker;
    localparam int REG_W = 4;
    localparam int ALU_W = 4;
    localparam int OFF_W = 8;
    localparam int STEP  = 4;
    localparam int RW    = REG_W + 1;
    localparam int UW    = 3 + ALU_W + 3 * RW + OFF_W + 1;
    localparam int TEMP  = 1 << REG_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [1:0] in_form = '0;
    logic [ALU_W-1:0] in_op = '0;
    logic [REG_W-1:0] in_rd = '0, in_rs = '0, in_rb = '0;
    logic [OFF_W-1:0] in_off = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [2:0] out_kind;
    logic [ALU_W-1:0] out_alu;
    logic [RW-1:0] out_rd, out_rs1, out_rs2;
    logic [OFF_W-1:0] out_imm;
    logic out_last;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mc_cracker #(.REG_W(REG_W), .ALU_W(ALU_W), .OFF_W(OFF_W), .COPY_STEP(STEP)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_form(in_form), .in_op(in_op), .in_rd(in_rd), .in_rs(in_rs),
        .in_rb(in_rb), .in_off(in_off), .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_alu(out_alu), .out_rd(out_rd), .out_rs1(out_rs1),
        .out_rs2(out_rs2), .out_imm(out_imm), .out_last(out_last)
    );

    function automatic int uop_len(int form);
        case (form)
            0: return 1;
            1: return 2;
            2: return 3;
            default: return 6;
        endcase
    endfunction

    function automatic logic [UW-1:0] pack(int k, int a, int d, int s1, int s2, int im, int l);
        return {3'(k), ALU_W'(a), RW'(d), RW'(s1), RW'(s2), OFF_W'(im), 1'(l)};
    endfunction

    function automatic logic [UW-1:0] exp_uop(int form, int op, int rd, int rs, int rb,
                                              int off, int idx);
        int l = (idx == uop_len(form) - 1) ? 1 : 0;
        case (form)
            0: return pack(0, op, rd, rd, rs, 0, l);
            1: if (idx == 0) return pack(1, 0, TEMP, rb, 0, off, l);
               else          return pack(0, op, rd, rd, TEMP, 0, l);
            2: if (idx == 0)      return pack(1, 0, TEMP, rb, 0, off, l);
               else if (idx == 1) return pack(0, op, TEMP, TEMP, rs, 0, l);
               else               return pack(2, 0, 0, rb, TEMP, off, l);
            default: case (idx)
                0: return pack(1, 0, TEMP, rs, 0, 0, l);
                1: return pack(2, 0, 0, rd, TEMP, 0, l);
                2: return pack(3, 0, rs, rs, 0, STEP, l);
                3: return pack(3, 0, rd, rd, 0, STEP, l);
                4: return pack(3, 0, rb, rb, 0, -1, l);
                default: return pack(4, 0, 0, rb, 0, off, l);
            endcase
        endcase
    endfunction

    function automatic string tag_of(int form);
        case (form)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(bit ok, string tag, logic [UW-1:0] act, logic [UW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_macro(int form, int op, int rd, int rs, int rb, int off, bit junk);
        int n = uop_len(form);
        int idx = 0;
        bit stalled = 0;
        int tries = 0;
        @(negedge clk);
        check(in_ready === 1'b1, "R2 ready when idle", UW'(in_ready), UW'(1));
        in_valid = 1'b1;
        in_form = 2'(form); in_op = ALU_W'(op);
        in_rd = REG_W'(rd); in_rs = REG_W'(rs); in_rb = REG_W'(rb); in_off = OFF_W'(off);
        out_ready = 1'b0;
        @(negedge clk);
        while (idx < n) begin
            logic [UW-1:0] act, exp;
            // junk on the input while busy must be ignored (R2)
            in_valid = junk;
            in_form = 2'($urandom); in_op = ALU_W'($urandom);
            in_rd = REG_W'($urandom); in_rs = REG_W'($urandom);
            in_rb = REG_W'($urandom); in_off = OFF_W'($urandom);
            act = {out_kind, out_alu, out_rd, out_rs1, out_rs2, out_imm, out_last};
            exp = exp_uop(form, op, rd, rs, rb, off, idx);
            check(out_valid === 1'b1 && act === exp,
                  stalled ? "R8 hold under stall" : (idx == n - 1 ? "R9 last/order" : tag_of(form)),
                  act, exp);
            check(in_ready === 1'b0, "R2 not ready while busy", UW'(in_ready), UW'(0));
            tries++;
            out_ready = (tries > 4) ? 1'b1 : 1'($urandom);
            stalled = !out_ready;
            if (out_ready) begin
                idx++;
                tries = 0;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        out_ready = 1'b0;
        check(out_valid === 1'b0 && in_ready === 1'b1, "R2 free after last",
              UW'({out_valid, in_ready}), UW'(2'b01));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=%h exp=%h", UW'(0), UW'(1));
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240607);
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b1, "R1 reset state",
              UW'({out_valid, in_ready}), UW'(2'b01));
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b1, "R1 after reset release",
              UW'({out_valid, in_ready}), UW'(2'b01));

        // directed corners
        run_macro(0, 15, 15, 0, 7, 255, 0);   // R3
        run_macro(1, 3, 0, 9, 15, 255, 1);    // R4, R7 temp next to reg 15
        run_macro(1, 0, 15, 2, 0, 0, 0);      // R4 zero offset
        run_macro(2, 7, 4, 15, 15, 128, 1);   // R5
        run_macro(3, 0, 15, 0, 8, 254, 1);    // R6 copy step
        run_macro(3, 9, 1, 2, 3, 0, 0);       // R6, op ignored

        // random mix
        for (int i = 0; i < 200; i++) begin
            run_macro(int'($urandom % 4), int'($urandom % 16), int'($urandom % 16),
                      int'($urandom % 16), int'($urandom % 16), int'($urandom % 256),
                      1'($urandom));
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule